// File: doc/BRIEF.md
# Serial Stuff-Bit Inserter and Remover

This block sits between the frame engine of a CAN controller and the bus bit pipe. It handles one bit per bit-time. A one-cycle strobe, `bit_tick`, marks each bit-time, and no state changes on clocks without it.

The transmit path takes frame bits from a valid/ready source. It places them on `tx_bus_bit`. After five equal bits it adds one bit of the opposite value and marks it on `tx_out_stuff`. For that bit-time it holds `tx_in_ready` low so the source stalls.

The receive path takes one sampled bus bit per strobe. It passes data bits on with a one-cycle `rx_out_valid` pulse. It drops the stuff bit that follows five equal bits. If the sixth bit has the same value as the five before it, the path pulses `rx_stuff_err` instead.

Each path has its own stuff-enable, so stuffing only covers the stuffed part of a frame. Each path also has a start-of-frame pulse that restarts its run count on the first bit of a frame.

The source handshake works like this:
- A bit is taken when `bit_tick`, `tx_in_valid` and `tx_in_ready` are all high in the same cycle.
- The source holds `tx_in_valid` and `tx_in_bit` steady until the bit is taken.
- `tx_in_ready` is a combinational output of the current run state, the enable and the start-of-frame input.
- The bus side of either path cannot push back.

Top module: `can_bitstuff_top`

## Requirements
- R1: After reset `tx_bus_bit` is 1 (recessive), `tx_in_ready` is 1, and `tx_out_valid`, `rx_out_valid` and `rx_stuff_err` are 0.
- R2: State changes only in cycles with `bit_tick` high. `tx_out_valid`, `rx_out_valid` and `rx_stuff_err` each pulse for one cycle, in the cycle right after the strobe that caused them.
- R3: With `tx_stuff_en` high, once five equal bits have gone onto the bus, the next strobe puts their complement on `tx_bus_bit` and sets `tx_out_stuff` to 1 with that bit. Data bits carry `tx_out_stuff` = 0.
- R4: An inserted stuff bit counts as the first bit of a new run. Four data bits equal to it then trigger the next stuff bit.
- R5: While a stuff bit is due, `tx_in_ready` is 0 and the strobe takes no source bit. Source bits go onto the bus in their original order.
- R6: A strobe with `tx_in_valid` low and no stuff bit due sends nothing. `tx_bus_bit` holds its value.
- R7: While `tx_stuff_en` is 0, source bits pass through with no insertion and the transmit run count is cleared. Stuffing after re-enable counts from zero.
- R8: `tx_sof` high on a strobe clears the transmit run count. The bit taken on that strobe is the first bit of a new run, and no stuff bit is due on that strobe.
- R9: With `rx_stuff_en` high, when five equal bits have been received and the next bit is their complement, that bit is dropped. It starts a new run of length one.
- R10: With `rx_stuff_en` high, a sixth bit equal to the five before it pulses `rx_stuff_err` and is not delivered. The receive run restarts with the following bit.
- R11: While `rx_stuff_en` is 0, every sampled bit is delivered, `rx_stuff_err` stays 0, and the receive run count is cleared.
- R12: `rx_sof` high on a strobe clears the receive run count. The bit sampled on that strobe is delivered as the first bit of a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_tick | input | 1 | One-cycle bit-time strobe shared by both paths |
| tx_sof | input | 1 | Transmit start-of-frame: restarts the run count |
| tx_stuff_en | input | 1 | Transmit stuffing enable |
| tx_in_valid | input | 1 | Source bit valid |
| tx_in_ready | output | 1 | Transmit path can take a source bit this bit-time |
| tx_in_bit | input | 1 | Source bit value |
| tx_bus_bit | output | 1 | Bit driven toward the bus, held between bit-times |
| tx_out_valid | output | 1 | Pulse: a new bit was placed on `tx_bus_bit` |
| tx_out_stuff | output | 1 | The current `tx_bus_bit` is an inserted stuff bit |
| rx_sof | input | 1 | Receive start-of-frame: restarts the run count |
| rx_stuff_en | input | 1 | Receive de-stuffing enable |
| rx_bus_bit | input | 1 | Sampled bus bit, taken on the strobe |
| rx_out_valid | output | 1 | Pulse: `rx_out_bit` holds a delivered data bit |
| rx_out_bit | output | 1 | Delivered data bit |
| rx_stuff_err | output | 1 | Pulse: six equal bits seen in the stuffed region |

## Verification
The properties take it as given that `bit_tick` is a single-cycle pulse with idle clocks between strobes. They also expect the start-of-frame and enable inputs to change only as frame boundaries require. Once `tx_in_valid` is raised, it must stay high with a steady bit until the bit is taken.

The stimulus keeps to these limits:
- It raises the strobe for exactly one clock, then leaves at least three idle clocks before the next one.
- It changes enables and start-of-frame only at strobe boundaries.
- It presents each source bit unchanged until a strobe finds `tx_in_ready` high.
- It runs the receive sequences while the transmit path is disabled and idle.

// File: rtl/can_stuff_pkg.sv
package can_stuff_pkg;
  // Longest run of equal bits allowed in the stuffed part of a frame.
  localparam int unsigned CAN_STUFF_RUN = 5;
endpackage

// File: rtl/can_run_tracker.sv
// Counts the current run of equal bits. The count saturates at RUN_LEN.
module can_run_tracker #(
  parameter int unsigned RUN_LEN = 5,
  localparam int unsigned CW = $clog2(RUN_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  input  logic          bit_in,
  output logic [CW-1:0] run_cnt,
  output logic          last_bit
);
  localparam logic [CW-1:0] CNT_MAX = CW'(RUN_LEN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt  <= '0;
      last_bit <= 1'b1;
    end else if (adv) begin
      last_bit <= bit_in;
      if (clr || run_cnt == '0 || bit_in != last_bit)
        run_cnt <= CW'(1);
      else if (run_cnt != CNT_MAX)
        run_cnt <= run_cnt + CW'(1);
    end else if (clr) begin
      run_cnt <= '0;
    end
  end
endmodule

// File: rtl/can_stuff_tx.sv
module can_stuff_tx #(
  parameter int unsigned RUN_LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic sof,
  input  logic stuff_en,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  output logic bus_bit,
  output logic out_valid,
  output logic out_stuff
);
  localparam int unsigned CW = $clog2(RUN_LEN + 1);

  logic [CW-1:0] run_cnt;
  logic          last_bit;
  logic          stuff_due;
  logic          emit;
  logic          emit_bit;

  // A stuff bit is owed once a full run has gone out, unless a new frame starts.
  assign stuff_due = stuff_en && !sof && (run_cnt == CW'(RUN_LEN));
  assign in_ready  = !stuff_due;
  assign emit      = bit_tick && (stuff_due || in_valid);
  assign emit_bit  = stuff_due ? ~last_bit : in_bit;

  can_run_tracker #(.RUN_LEN(RUN_LEN)) u_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (sof || !stuff_en),
    .adv      (emit && stuff_en),
    .bit_in   (emit_bit),
    .run_cnt  (run_cnt),
    .last_bit (last_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_bit   <= 1'b1;
      out_valid <= 1'b0;
      out_stuff <= 1'b0;
    end else begin
      out_valid <= emit;
      if (emit) begin
        bus_bit   <= emit_bit;
        out_stuff <= stuff_due;
      end
    end
  end
endmodule

// File: rtl/can_destuff_rx.sv
module can_destuff_rx #(
  parameter int unsigned RUN_LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic sof,
  input  logic stuff_en,
  input  logic bus_bit,
  output logic out_valid,
  output logic out_bit,
  output logic stuff_err
);
  localparam int unsigned CW = $clog2(RUN_LEN + 1);

  logic [CW-1:0] run_cnt;
  logic          last_bit;
  logic          at_limit;
  logic          err_now;
  logic          deliver;

  // The bit after a full run is either a stuff bit (dropped) or a violation.
  assign at_limit = stuff_en && !sof && (run_cnt == CW'(RUN_LEN));
  assign err_now  = bit_tick && at_limit && (bus_bit == last_bit);
  assign deliver  = bit_tick && !at_limit;

  can_run_tracker #(.RUN_LEN(RUN_LEN)) u_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (sof || !stuff_en || err_now),
    .adv      (bit_tick && stuff_en && !err_now),
    .bit_in   (bus_bit),
    .run_cnt  (run_cnt),
    .last_bit (last_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
      stuff_err <= 1'b0;
    end else begin
      out_valid <= deliver;
      stuff_err <= err_now;
      if (deliver) out_bit <= bus_bit;
    end
  end
endmodule

// File: rtl/can_bitstuff_top.sv
module can_bitstuff_top #(
  parameter int unsigned RUN_LEN = can_stuff_pkg::CAN_STUFF_RUN
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic tx_sof,
  input  logic tx_stuff_en,
  input  logic tx_in_valid,
  output logic tx_in_ready,
  input  logic tx_in_bit,
  output logic tx_bus_bit,
  output logic tx_out_valid,
  output logic tx_out_stuff,
  input  logic rx_sof,
  input  logic rx_stuff_en,
  input  logic rx_bus_bit,
  output logic rx_out_valid,
  output logic rx_out_bit,
  output logic rx_stuff_err
);
  can_stuff_tx #(.RUN_LEN(RUN_LEN)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .sof       (tx_sof),
    .stuff_en  (tx_stuff_en),
    .in_valid  (tx_in_valid),
    .in_ready  (tx_in_ready),
    .in_bit    (tx_in_bit),
    .bus_bit   (tx_bus_bit),
    .out_valid (tx_out_valid),
    .out_stuff (tx_out_stuff)
  );

  can_destuff_rx #(.RUN_LEN(RUN_LEN)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .sof       (rx_sof),
    .stuff_en  (rx_stuff_en),
    .bus_bit   (rx_bus_bit),
    .out_valid (rx_out_valid),
    .out_bit   (rx_out_bit),
    .stuff_err (rx_stuff_err)
  );
endmodule

// File: rtl/can_bitstuff_chk.sv
module can_bitstuff_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_tick,
  input logic tx_stuff_en,
  input logic tx_in_ready,
  input logic tx_bus_bit,
  input logic tx_out_valid,
  input logic tx_out_stuff,
  input logic rx_sof,
  input logic rx_stuff_en,
  input logic rx_out_valid,
  input logic rx_stuff_err
);
  // R2: transmit output pulses only after a strobe
  a_r2_tx_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid |-> $past(bit_tick));

  // R2: receive outputs pulse only after a strobe
  a_r2_rx_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_out_valid || rx_stuff_err) |-> $past(bit_tick));

  // R3: an inserted bit is the complement of the bit before it
  a_r3_stuff_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out_valid && tx_out_stuff) |-> (tx_bus_bit != $past(tx_bus_bit)));

  // R5: the source saw ready low during the bit-time of a stuff bit
  a_r5_stuff_ready_low: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out_valid && tx_out_stuff) |-> !$past(tx_in_ready));

  // R7: no insertion while transmit stuffing is disabled
  a_r7_no_stuff_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out_valid && tx_out_stuff) |-> $past(tx_stuff_en));

  // R10: a flagged bit is never also delivered
  a_r10_err_not_data: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stuff_err |-> !rx_out_valid);

  // R11 / R12: no error while disabled or on a start-of-frame strobe
  a_r11_no_err_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    rx_stuff_err |-> ($past(rx_stuff_en) && !$past(rx_sof)));
endmodule

bind can_bitstuff_top can_bitstuff_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bit_tick     (bit_tick),
  .tx_stuff_en  (tx_stuff_en),
  .tx_in_ready  (tx_in_ready),
  .tx_bus_bit   (tx_bus_bit),
  .tx_out_valid (tx_out_valid),
  .tx_out_stuff (tx_out_stuff),
  .rx_sof       (rx_sof),
  .rx_stuff_en  (rx_stuff_en),
  .rx_out_valid (rx_out_valid),
  .rx_stuff_err (rx_stuff_err)
);

// File: tb/can_bitstuff_top_tb.sv
`timescale 1ns/1ps
module can_bitstuff_top_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0;
  logic tx_sof = 1'b0, tx_stuff_en = 1'b0, tx_in_valid = 1'b0, tx_in_bit = 1'b0;
  logic rx_sof = 1'b0, rx_stuff_en = 1'b0, rx_bus_bit = 1'b1;
  logic tx_in_ready, tx_bus_bit, tx_out_valid, tx_out_stuff;
  logic rx_out_valid, rx_out_bit, rx_stuff_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  bit rx_watch = 1'b0;
  string cur_tag = "R3";

  logic [1:0] tx_q[$];  // {stuff, bit}
  logic [1:0] rx_q[$];  // {err, bit}

  int m_cnt = 0;
  logic m_last = 1'b1;

  always #2.5 clk = ~clk;

  can_bitstuff_top u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
    .tx_sof(tx_sof), .tx_stuff_en(tx_stuff_en), .tx_in_valid(tx_in_valid),
    .tx_in_ready(tx_in_ready), .tx_in_bit(tx_in_bit), .tx_bus_bit(tx_bus_bit),
    .tx_out_valid(tx_out_valid), .tx_out_stuff(tx_out_stuff),
    .rx_sof(rx_sof), .rx_stuff_en(rx_stuff_en), .rx_bus_bit(rx_bus_bit),
    .rx_out_valid(rx_out_valid), .rx_out_bit(rx_out_bit), .rx_stuff_err(rx_stuff_err)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_out_valid) begin
        if (tx_q.size() == 0) chk(1'b0, cur_tag, "unexpected tx bit", int'({tx_out_stuff, tx_bus_bit}), -1);
        else begin
          logic [1:0] e;
          e = tx_q.pop_front();
          chk({tx_out_stuff, tx_bus_bit} == e, cur_tag, "tx {stuff,bit}", int'({tx_out_stuff, tx_bus_bit}), int'(e));
        end
      end
      if (rx_watch && (rx_out_valid || rx_stuff_err)) begin
        logic [1:0] a;
        a = {rx_stuff_err, rx_out_valid & rx_out_bit};
        if (rx_q.size() == 0) chk(1'b0, cur_tag, "unexpected rx item", int'(a), -1);
        else begin
          logic [1:0] e;
          e = rx_q.pop_front();
          chk(a == e, cur_tag, "rx {err,bit}", int'(a), int'(e));
        end
      end
    end
  end

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "WATCHDOG", "run did not end", 0, 1);
      finish_up();
    end
  end

  // Transmit expectation model built from R3, R4, R7, R8
  task automatic tx_model(input logic [63:0] pl, input int n, input bit en,
                          input bit sof_first, input int sof_idx, output int nstuff);
    nstuff = 0;
    for (int i = 0; i < n; i++) begin
      logic b;
      bit sh;
      b = pl[n-1-i];
      sh = (i == 0 && sof_first) || (i == sof_idx);
      if (en && !sh && m_cnt == 5) begin
        tx_q.push_back({1'b1, ~m_last});
        nstuff++;
        m_last = ~m_last;
        m_cnt = 1;
      end
      tx_q.push_back({1'b0, b});
      if (!en) m_cnt = 0;
      else if (sh || m_cnt == 0 || b != m_last) m_cnt = 1;
      else if (m_cnt < 5) m_cnt++;
      m_last = b;
    end
    if (en && m_cnt == 5) begin
      tx_q.push_back({1'b1, ~m_last});
      nstuff++;
      m_last = ~m_last;
      m_cnt = 1;
    end
  endtask

  task automatic tx_send(input logic [63:0] pl, input int n, input bit en,
                         input bit sof_first, input int sof_idx, input string tag);
    int nstuff;
    int rlow;
    int i;
    cur_tag = tag;
    tx_model(pl, n, en, sof_first, sof_idx, nstuff);
    rlow = 0;
    i = 0;
    while (i <= n) begin
      @(negedge clk);
      tx_stuff_en = en;
      tx_in_valid = (i < n);
      tx_in_bit = (i < n) ? pl[n-1-i] : 1'b0;
      tx_sof = (i < n) && ((i == 0 && sof_first) || (i == sof_idx));
      bit_tick = 1'b1;
      #1;
      if (!tx_in_ready) rlow++;
      else i++;
      if (i == n + 1) ;
      @(negedge clk);
      bit_tick = 1'b0;
      tx_sof = 1'b0;
      tx_in_valid = 1'b0;
      repeat (2) @(negedge clk);
      if (i == n && !(en && m_cnt == 1 && nstuff > 0 && tx_q.size() != 0)) begin
        if (tx_q.size() == 0) i = n + 1;
      end
    end
    repeat (2) @(negedge clk);
    chk(tx_q.size() == 0, tag, "expected tx bits left unsent", tx_q.size(), 0);
    chk(rlow == nstuff, "R5", "ready-low bit-times vs stuff bits", rlow, nstuff);
  endtask

  // Receive expectation model built from R9..R12
  task automatic rx_send(input logic [63:0] sq, input int n, input bit en,
                         input int sof_idx, input string tag);
    int r_cnt;
    logic r_last;
    cur_tag = tag;
    r_cnt = 0;
    r_last = 1'b1;
    for (int i = 0; i < n; i++) begin
      logic b;
      bit sh;
      bit lim;
      b = sq[n-1-i];
      sh = (i == 0) || (i == sof_idx);
      lim = en && !sh && r_cnt == 5;
      if (lim && b == r_last) begin
        rx_q.push_back(2'b10);
        r_cnt = 0;
      end else if (lim) begin
        r_cnt = 1;
        r_last = b;
      end else begin
        rx_q.push_back({1'b0, b});
        if (!en) r_cnt = 0;
        else if (sh || r_cnt == 0 || b != r_last) r_cnt = 1;
        else if (r_cnt < 5) r_cnt++;
        r_last = b;
      end
    end
    rx_watch = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_stuff_en = en;
      rx_bus_bit = sq[n-1-i];
      rx_sof = (i == 0) || (i == sof_idx);
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
      rx_sof = 1'b0;
      repeat (2) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    rx_watch = 1'b0;
    rx_stuff_en = 1'b0;
    chk(rx_q.size() == 0, tag, "expected rx items not seen", rx_q.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset values
    chk(tx_bus_bit == 1'b1, "R1", "tx_bus_bit in reset", tx_bus_bit, 1);
    chk(tx_in_ready == 1'b1, "R1", "tx_in_ready in reset", tx_in_ready, 1);
    chk(!tx_out_valid && !rx_out_valid && !rx_stuff_err, "R1", "pulses in reset",
        int'({tx_out_valid, rx_out_valid, rx_stuff_err}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2: no strobe, nothing moves
    tx_stuff_en = 1'b1;
    tx_in_valid = 1'b1;
    tx_in_bit = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(!tx_out_valid && tx_bus_bit == 1'b1, "R2", "tx moved without strobe",
          int'({tx_out_valid, tx_bus_bit}), 1);
    end
    tx_in_valid = 1'b0;

    // R3: long run of zeros
    tx_send(64'b0000000000, 10, 1'b1, 1'b1, -1, "R3");
    // R3: mixed pattern with runs of both values
    tx_send(64'h0000_0000_F83E_0F1F, 32, 1'b1, 1'b1, -1, "R3");
    // R4: stuff bit followed by four equal data bits
    tx_send(64'b0000011110, 10, 1'b1, 1'b1, -1, "R4");
    // R8: start-of-frame mid-run restarts the count
    tx_send(64'b000000, 6, 1'b1, 1'b1, 3, "R8");

    // R6: idle strobe with no stuff due
    tx_send(64'b101, 3, 1'b1, 1'b1, -1, "R6");
    begin
      logic held;
      held = tx_bus_bit;
      @(negedge clk);
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
      chk(!tx_out_valid, "R6", "bit sent on idle strobe", tx_out_valid, 0);
      chk(tx_bus_bit == held, "R6", "bus bit changed on idle strobe", tx_bus_bit, held);
      repeat (2) @(negedge clk);
    end

    // R7: disabling clears the run; pass-through has no insertion
    tx_send(64'b0000, 4, 1'b1, 1'b1, -1, "R7");
    tx_send(64'b0, 1, 1'b0, 1'b0, -1, "R7");
    tx_send(64'b0000, 4, 1'b1, 1'b0, -1, "R7");
    tx_send(64'b00000000, 8, 1'b0, 1'b1, -1, "R7");
    tx_stuff_en = 1'b0;

    // R9: stuff bits removed
    rx_send(64'b1111101111001, 13, 1'b1, -1, "R9");
    rx_send(64'b00000100001000, 14, 1'b1, -1, "R9");
    // R10: sixth equal bit flagged
    rx_send(64'b00000011, 8, 1'b1, -1, "R10");
    rx_send(64'b1111110, 7, 1'b1, -1, "R10");
    // R11: disabled path delivers everything
    rx_send(64'b00000000, 8, 1'b0, -1, "R11");
    // R12: start-of-frame mid-run restarts the count
    rx_send(64'b00000000, 8, 1'b1, 4, "R12");

    done = 1'b1;
    finish_up();
  end
endmodule